// File: doc/BRIEF.md
# Queue-Driven Clock and Supply Governor

This block sits beside one core of a tiled chip and chooses the core's operating point from how often its stream buffers stall. Two single-cycle pulse inputs report stalls. An input-side stall means the core could not accept data that the interconnect offered, so the core is too slow. An output-side stall means the interconnect could not drain what the core produced, so the core is too fast. The block counts both kinds of stall over a fixed window of interconnect cycles. At the end of each window it moves the operating point one step faster, one step slower, or leaves it where it is.

An operating point pairs a clock division with a supply rail. The divisor is 1, 2, 4 or 8. The block drives a clock enable that pulses once per divided period, a divider select, and a select among four pre-routed supplies. In a speed-up the supply is raised before the clock gets faster. In a slow-down the clock gets slower before the supply is dropped. A change of divisor takes effect only at the end of a divided period. A tile-level override can pin the operating point. The counts from the last completed window are reported on status outputs.

Top module: `tile_perf_governor`

## Requirements
- R1: While reset is asserted and just after it is released, `div_sel` and `rail_sel` are 0, both status counts are 0, and `clk_en` is high in every cycle.
- R2: The window is WIN cycles long. At the window's last edge, `stat_in` and `stat_out` take the number of cycles in that window in which `in_blocked` and `out_blocked` were high. They hold those values until the next window ends, and neither value ever exceeds WIN.
- R3: A window whose input-stall count is strictly greater than UP_TH, and whose output-stall count is not greater than DN_TH, lowers the level index by one. The index does not go below 0.
- R4: A window whose output-stall count is strictly greater than DN_TH, and whose input-stall count is not greater than UP_TH, raises the level index by one. The index does not go above 3.
- R5: The level is unchanged when both counts exceed their thresholds, or when neither does. A count equal to its threshold does not exceed it.
- R6: With `div_sel` = d, `clk_en` pulses exactly once every 2^d cycles (0 is full speed, 3 is one eighth). `div_sel` changes only in a cycle in which `clk_en` is high, so every divided period has the full length of either the old divisor or the new one.
- R7: `rail_sel` = 0 selects the highest supply and 3 selects the lowest. Once a transition has completed, `rail_sel` equals `div_sel`.
- R8: In a speed-up, `rail_sel` takes the new level at the same edge that ends the deciding window. `div_sel` follows after SETTLE cycles, at the next `clk_en` pulse.
- R9: In a slow-down, `div_sel` changes first, at a `clk_en` pulse. `rail_sel` follows SETTLE cycles later. At no time is `rail_sel` greater than `div_sel`.
- R10: While `force_en` is high, the level moves to `force_lvl`, jumping several steps if needed, and window decisions are ignored. After `force_en` is released, the forced level is kept until a later window decides otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_blocked | input | 1 | Input buffer stalled this cycle |
| out_blocked | input | 1 | Output buffer stalled this cycle |
| force_en | input | 1 | Override the automatic choice |
| force_lvl | input | $clog2(NLVL) | Level used while overridden |
| div_sel | output | $clog2(NLVL) | Clock division exponent (divide by 2^div_sel) |
| rail_sel | output | $clog2(NLVL) | Supply rail select, 0 = highest |
| clk_en | output | 1 | One pulse per divided clock period |
| stat_in | output | $clog2(WIN+1) | Input stalls in last completed window |
| stat_out | output | $clog2(WIN+1) | Output stalls in last completed window |

## Verification
Five properties are checked on every cycle:
- the supply rail is never lower than the divider requires;
- the divisor changes only on an enable pulse;
- each enable pulse arrives exactly one divided period after the previous one;
- the status counts change only at window boundaries;
- the status counts never exceed the window length.

The threshold decisions, including the equal-to-threshold, saturation and both-exceed cases, can only be shown by the bench's scenarios. The same holds for the order of rail and divider moves at a window boundary and for the override and its release. For these the bench drives a known stall pattern into each window and compares the level, the pulse spacing and the reported counts with a model of its own.

// File: rtl/tile_perf_governor.sv
module tile_perf_governor #(
  parameter int WIN    = 256,
  parameter int UP_TH  = 32,
  parameter int DN_TH  = 32,
  parameter int SETTLE = 16,
  parameter int NLVL   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_blocked,
  input  logic                      out_blocked,
  input  logic                      force_en,
  input  logic [$clog2(NLVL)-1:0]   force_lvl,
  output logic [$clog2(NLVL)-1:0]   div_sel,
  output logic [$clog2(NLVL)-1:0]   rail_sel,
  output logic                      clk_en,
  output logic [$clog2(WIN+1)-1:0]  stat_in,
  output logic [$clog2(WIN+1)-1:0]  stat_out
);
  localparam int CW = $clog2(WIN+1);
  localparam int WW = $clog2(WIN);
  localparam int SW = $clog2(SETTLE+1);
  localparam int LW = $clog2(NLVL);
  localparam int DW = NLVL-1;
  localparam logic [LW-1:0] LMAX = LW'(NLVL-1);

  typedef enum logic [2:0] {S_IDLE, S_UP_SET, S_UP_EDGE, S_DN_EDGE, S_DN_SET} st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] acc_in, acc_out;
  logic [DW-1:0] dcnt;
  logic [SW-1:0] scnt;
  logic [LW-1:0] tgt, auto_lvl;

  wire           wend   = wcnt == WW'(WIN-1);
  wire [CW-1:0]  fin    = acc_in  + CW'(in_blocked);
  wire [CW-1:0]  fout   = acc_out + CW'(out_blocked);
  wire           up_hit = fin  > CW'(UP_TH);
  wire           dn_hit = fout > CW'(DN_TH);
  wire [DW-1:0]  mask   = DW'((1 << div_sel) - 1);
  wire           sdone  = scnt == SW'(SETTLE-1);

  assign clk_en = dcnt == mask;

  always_comb begin
    auto_lvl = div_sel;
    if (wend && up_hit && !dn_hit && div_sel != '0)
      auto_lvl = div_sel - LW'(1);
    else if (wend && dn_hit && !up_hit && div_sel != LMAX)
      auto_lvl = div_sel + LW'(1);
  end

  wire [LW-1:0] want = force_en ? force_lvl : auto_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt     <= '0;
      acc_in   <= '0;
      acc_out  <= '0;
      stat_in  <= '0;
      stat_out <= '0;
      dcnt     <= '0;
      scnt     <= '0;
      tgt      <= '0;
      div_sel  <= '0;
      rail_sel <= '0;
      st       <= S_IDLE;
    end else begin
      wcnt <= wend ? '0 : wcnt + WW'(1);
      if (wend) begin
        stat_in  <= fin;
        stat_out <= fout;
        acc_in   <= '0;
        acc_out  <= '0;
      end else begin
        acc_in   <= fin;
        acc_out  <= fout;
      end
      dcnt <= clk_en ? '0 : dcnt + DW'(1);
      case (st)
        S_IDLE: begin
          if (want < div_sel) begin
            rail_sel <= want;
            tgt      <= want;
            scnt     <= '0;
            st       <= S_UP_SET;
          end else if (want > div_sel) begin
            tgt <= want;
            st  <= S_DN_EDGE;
          end
        end
        S_UP_SET: begin
          if (sdone) st <= S_UP_EDGE;
          else       scnt <= scnt + SW'(1);
        end
        S_UP_EDGE: begin
          if (clk_en) begin
            div_sel <= tgt;
            st      <= S_IDLE;
          end
        end
        S_DN_EDGE: begin
          if (clk_en) begin
            div_sel <= tgt;
            scnt    <= '0;
            st      <= S_DN_SET;
          end
        end
        S_DN_SET: begin
          if (sdone) begin
            rail_sel <= tgt;
            st       <= S_IDLE;
          end else begin
            scnt <= scnt + SW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_perf_governor_chk.sv
module tile_perf_governor_chk #(
  parameter int WIN  = 256,
  parameter int NLVL = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(NLVL)-1:0]  div_sel,
  input logic [$clog2(NLVL)-1:0]  rail_sel,
  input logic                     clk_en,
  input logic [$clog2(WIN+1)-1:0] stat_in,
  input logic [$clog2(WIN+1)-1:0] stat_out
);
  localparam int WW = $clog2(WIN);
  localparam int CW = $clog2(WIN+1);
  localparam int GW = NLVL + 1;

  logic [WW-1:0] wc;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc  <= '0;
      gap <= GW'(1);
    end else begin
      wc  <= (wc == WW'(WIN-1)) ? '0 : wc + WW'(1);
      gap <= clk_en ? GW'(1) : gap + GW'(1);
    end
  end

  p_rail_leads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rail_sel <= div_sel);

  p_div_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(clk_en));

  p_pulse_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> gap == GW'(1 << div_sel));

  p_stat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(stat_in) || !$stable(stat_out)) |-> $past(wc) == WW'(WIN-1));

  p_stat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_in <= CW'(WIN) && stat_out <= CW'(WIN));
endmodule

bind tile_perf_governor tile_perf_governor_chk #(.WIN(WIN), .NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .rail_sel(rail_sel),
  .clk_en(clk_en), .stat_in(stat_in), .stat_out(stat_out)
);

// File: tb/test_tile_perf_governor.sv
module test_tile_perf_governor;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 256, UP_TH = 32, DN_TH = 32, SETTLE = 16, NLVL = 4;

  logic clk = 0, rst_n = 0, in_blocked = 0, out_blocked = 0, force_en = 0;
  logic [1:0] force_lvl = 0;
  logic [1:0] div_sel, rail_sel;
  logic clk_en;
  logic [8:0] stat_in, stat_out;

  int checks = 0, errors = 0, m_lvl = 0, tgap = 1, last_gap = 0;
  int q_in[$], q_out[$], q_mid[$], q_nxt[$];
  string q_tag[$];
  localparam int NWIN = 17;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_perf_governor #(.WIN(WIN), .UP_TH(UP_TH), .DN_TH(DN_TH), .SETTLE(SETTLE), .NLVL(NLVL))
    i_tile_perf_governor (.clk(clk), .rst_n(rst_n), .in_blocked(in_blocked), .out_blocked(out_blocked),
      .force_en(force_en), .force_lvl(force_lvl), .div_sel(div_sel), .rail_sel(rail_sel),
      .clk_en(clk_en), .stat_in(stat_in), .stat_out(stat_out));

  always @(negedge clk) begin
    if (clk_en) begin last_gap = tgap; tgap = 1; end
    else tgap++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_win(int nin, int nout, bit frc, int flvl, string tag);
    int mid, nxt;
    bit up, dn;
    mid = frc ? flvl : m_lvl;
    up = nin > UP_TH && !(nout > DN_TH);
    dn = nout > DN_TH && !(nin > UP_TH);
    nxt = mid;
    if (!frc && up && mid > 0) nxt = mid - 1;
    else if (!frc && dn && mid < NLVL-1) nxt = mid + 1;
    m_lvl = nxt;
    q_in.push_back(nin); q_out.push_back(nout);
    q_mid.push_back(mid); q_nxt.push_back(nxt); q_tag.push_back(tag);
    force_en = frc;
    force_lvl = 2'(flvl);
    for (int i = 0; i < WIN; i++) begin
      in_blocked = i < nin;
      out_blocked = i >= WIN - nout;
      @(negedge clk);
    end
    in_blocked = 0; out_blocked = 0;
  endtask

  task automatic monitor();
    for (int w = 0; w < NWIN; w++) begin
      int nin, nout, mid, nxt;
      string tag;
      repeat (WIN/2) @(negedge clk);
      if (q_mid.size() == 0) begin
        chk(0, "R2", 0, 1);
        return;
      end
      nin = q_in.pop_front(); nout = q_out.pop_front();
      mid = q_mid.pop_front(); nxt = q_nxt.pop_front(); tag = q_tag.pop_front();
      chk(div_sel == 2'(mid), tag, div_sel, mid);
      chk(rail_sel == 2'(mid), "R7", rail_sel, mid);
      chk(last_gap == (1 << mid), "R6", last_gap, 1 << mid);
      repeat (WIN/2) @(negedge clk);
      chk(stat_in == 9'(nin), "R2", stat_in, nin);
      chk(stat_out == 9'(nout), "R2", stat_out, nout);
      if (nxt < mid) begin
        chk(rail_sel == 2'(nxt), "R8", rail_sel, nxt);
        chk(div_sel == 2'(mid), "R8", div_sel, mid);
      end else if (nxt > mid) begin
        chk(rail_sel == 2'(mid), "R9", rail_sel, mid);
        chk(div_sel == 2'(mid), "R9", div_sel, mid);
      end else begin
        chk(rail_sel == 2'(mid) && div_sel == 2'(mid), "R5", div_sel, mid);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(div_sel == 0, "R1", div_sel, 0);
    chk(rail_sel == 0, "R1", rail_sel, 0);
    chk(stat_in == 0 && stat_out == 0, "R1", stat_in, 0);
    chk(clk_en == 1, "R1", clk_en, 1);
    rst_n = 1;
    fork
      begin
        run_win(10, 0, 0, 0, "R1");
        run_win(0, 40, 0, 0, "R5");
        run_win(0, 33, 0, 0, "R4");
        run_win(0, 32, 0, 0, "R4");
        run_win(0, 200, 0, 0, "R5");
        run_win(0, 256, 0, 0, "R4");
        run_win(40, 40, 0, 0, "R4");
        run_win(33, 0, 0, 0, "R5");
        run_win(256, 0, 0, 0, "R3");
        run_win(100, 5, 0, 0, "R3");
        run_win(256, 0, 0, 0, "R3");
        run_win(256, 0, 1, 3, "R10");
        run_win(0, 256, 1, 1, "R10");
        run_win(0, 0, 0, 0, "R10");
        run_win(0, 0, 1, 0, "R10");
        run_win(0, 50, 0, 0, "R10");
        run_win(0, 0, 0, 0, "R4");
      end
      monitor();
    join
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule